// File: doc/BRIEF.md
# AHB Passive Transfer Tap

This block sits beside an AHB-Lite bus and only listens. Every pin it has on the bus side is an input, so it cannot change anything the master or slave does. It watches the pipelined bus, where the address and control of a transfer appear one cycle (or more) before that transfer's data, and rebuilds each completed transfer as a single record. The record holds the address, the direction, the size, the burst type, the data that moved and the slave's response.

An address phase counts only when the bus accepts it: HREADY is high at the clock edge and the transfer type is NONSEQ or SEQ. The block keeps that context while the slave inserts wait states. When the data phase ends with HREADY high, it takes the write data or the read data, according to the held direction, together with the response, and emits the record. The output is a stream that carries a valid strobe and no ready. A passive observer cannot stall the bus, so there is no back-pressure. Any consumer must accept each record in the one cycle it is presented. Two records can follow on consecutive cycles. A count of emitted records is also provided, so that a testbench can compare totals.

Top module: `ahb_xfer_tap`

## Requirements
- R1: An address phase is captured at a rising edge of hclk only when hready is 1 and htrans is NONSEQ (2'b10) or SEQ (2'b11).
- R2: A cycle whose htrans is IDLE (2'b00) or BUSY (2'b01) never produces a record, even when hready is 1.
- R3: A record reports the haddr, hwrite, hsize and hburst values of the accepted address phase it belongs to.
- R4: While hready is 0 the held context is unchanged, and address or data values present during wait cycles do not appear in the record. The data and response come from the edge where the data phase completes.
- R5: The record data is hwdata for a write (hwrite=1) and hrdata for a read (hwrite=0). rec_resp is hresp (0 = OKAY, 1 = ERROR) at the completing edge.
- R6: rec_valid is high for exactly one cycle per completed transfer, starting the cycle after the completing edge. It is never high without a previously captured context.
- R7: Transfers are reported oldest first. An address phase accepted on the same edge that an earlier data phase completes yields both records, in order and correctly paired.
- R8: A two-cycle ERROR response (hresp=1 with hready=0, then hresp=1 with hready=1) produces one record with rec_resp=1 on the second cycle. An address phase offered during the first cycle and then withdrawn produces no record.
- R9: hresetn=0 (asynchronous, active low) clears rec_valid, rec_count and any pending context. A context captured before reset never produces a record.
- R10: rec_count increases by exactly one with each record and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| haddr | input | ADDR_W | Bus address |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | Direction, 1 = write |
| hsize | input | 3 | Transfer size |
| hburst | input | 3 | Burst type |
| hwdata | input | DATA_W | Write data |
| hrdata | input | DATA_W | Read data |
| hready | input | 1 | Transfer done / bus ready |
| hresp | input | 1 | Slave response, 1 = ERROR |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_addr | output | ADDR_W | Record address |
| rec_write | output | 1 | Record direction |
| rec_size | output | 3 | Record size |
| rec_burst | output | 3 | Record burst type |
| rec_data | output | DATA_W | Record data |
| rec_resp | output | 1 | Record response |
| rec_count | output | CNT_W | Number of records emitted since reset |

## Verification
A wrong internal state shows up at the ports one cycle after the next edge where hready is high. Three cases are possible. A stale or lost pending flag produces a record that was never expected, or fails to produce one that was. A context overwritten during a wait state produces a record with the wrong address or control fields. A data select on the wrong side produces the other bus's data value. The directed traffic therefore places deliberately wrong values on the inactive inputs during wait, BUSY, IDLE and reset cycles, so that any such fault turns into a visible field mismatch or an extra record.

// File: rtl/ahb_tap_pkg.sv
package ahb_tap_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam int SIZE_W  = 3;
  localparam int BURST_W = 3;

  typedef struct packed {
    logic               write;
    logic [SIZE_W-1:0]  size;
    logic [BURST_W-1:0] burst;
  } ctl_t;

endpackage

// File: rtl/ahb_tap_qual.sv
module ahb_tap_qual
  import ahb_tap_pkg::*;
(
  input  logic [1:0] htrans,
  input  logic       hready,
  output logic       accept
);

  logic real_xfer;

  always_comb begin
    real_xfer = (htrans == TR_NONSEQ) || (htrans == TR_SEQ);
    accept    = hready && real_xfer;
  end

endmodule

// File: rtl/ahb_tap_ctx.sv
module ahb_tap_ctx
  import ahb_tap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hready,
  input  logic              accept,
  input  logic [ADDR_W-1:0] haddr,
  input  ctl_t              ctl_in,
  output logic              pend_valid,
  output logic [ADDR_W-1:0] pend_addr,
  output ctl_t              pend_ctl
);

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_ctl   <= '0;
    end else if (hready) begin
      pend_valid <= accept;
      if (accept) begin
        pend_addr <= haddr;
        pend_ctl  <= ctl_in;
      end
    end
  end

  AST_CAPTURE_ON_ACCEPT: assert property (@(posedge hclk) disable iff (!hresetn)
    accept |=> pend_valid);  // R1

  AST_HOLD_IN_WAIT: assert property (@(posedge hclk) disable iff (!hresetn)
    (pend_valid && !hready) |=> (pend_valid && $stable(pend_addr) && $stable(pend_ctl)));  // R4

endmodule

// File: rtl/ahb_tap_emit.sv
module ahb_tap_emit
  import ahb_tap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic               hclk,
  input  logic               hresetn,
  input  logic               hready,
  input  logic               pend_valid,
  input  logic [ADDR_W-1:0]  pend_addr,
  input  ctl_t               pend_ctl,
  input  logic [DATA_W-1:0]  hwdata,
  input  logic [DATA_W-1:0]  hrdata,
  input  logic               hresp,
  output logic               rec_valid,
  output logic [ADDR_W-1:0]  rec_addr,
  output ctl_t               rec_ctl,
  output logic [DATA_W-1:0]  rec_data,
  output logic               rec_resp,
  output logic [CNT_W-1:0]   rec_count
);

  logic              done;
  logic [DATA_W-1:0] data_sel;

  always_comb begin
    done     = pend_valid && hready;
    data_sel = pend_ctl.write ? hwdata : hrdata;
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      rec_valid <= 1'b0;
      rec_addr  <= '0;
      rec_ctl   <= '0;
      rec_data  <= '0;
      rec_resp  <= 1'b0;
      rec_count <= '0;
    end else begin
      rec_valid <= done;
      if (done) begin
        rec_addr  <= pend_addr;
        rec_ctl   <= pend_ctl;
        rec_data  <= data_sel;
        rec_resp  <= hresp;
        rec_count <= rec_count + 1'b1;
      end
    end
  end

  AST_VALID_HAS_CONTEXT: assert property (@(posedge hclk) disable iff (!hresetn)
    rec_valid |-> $past(pend_valid));  // R6

  AST_COUNT_STEP: assert property (@(posedge hclk) disable iff (!hresetn)
    rec_valid |-> (rec_count == $past(rec_count) + CNT_W'(1)));  // R10

  AST_COUNT_HOLD: assert property (@(posedge hclk) disable iff (!hresetn)
    !rec_valid |-> $stable(rec_count));  // R10

endmodule

// File: rtl/ahb_xfer_tap.sv
module ahb_xfer_tap
  import ahb_tap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic               hclk,
  input  logic               hresetn,
  input  logic [ADDR_W-1:0]  haddr,
  input  logic [1:0]         htrans,
  input  logic               hwrite,
  input  logic [2:0]         hsize,
  input  logic [2:0]         hburst,
  input  logic [DATA_W-1:0]  hwdata,
  input  logic [DATA_W-1:0]  hrdata,
  input  logic               hready,
  input  logic               hresp,
  output logic               rec_valid,
  output logic [ADDR_W-1:0]  rec_addr,
  output logic               rec_write,
  output logic [2:0]         rec_size,
  output logic [2:0]         rec_burst,
  output logic [DATA_W-1:0]  rec_data,
  output logic               rec_resp,
  output logic [CNT_W-1:0]   rec_count
);

  logic              accept;
  ctl_t              ctl_in;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  ctl_t              pend_ctl;
  ctl_t              rec_ctl;

  always_comb begin
    ctl_in.write = hwrite;
    ctl_in.size  = hsize;
    ctl_in.burst = hburst;
  end

  ahb_tap_qual u_qual (
    .htrans (htrans),
    .hready (hready),
    .accept (accept)
  );

  ahb_tap_ctx #(.ADDR_W(ADDR_W)) u_ctx (
    .hclk       (hclk),
    .hresetn    (hresetn),
    .hready     (hready),
    .accept     (accept),
    .haddr      (haddr),
    .ctl_in     (ctl_in),
    .pend_valid (pend_valid),
    .pend_addr  (pend_addr),
    .pend_ctl   (pend_ctl)
  );

  ahb_tap_emit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_emit (
    .hclk       (hclk),
    .hresetn    (hresetn),
    .hready     (hready),
    .pend_valid (pend_valid),
    .pend_addr  (pend_addr),
    .pend_ctl   (pend_ctl),
    .hwdata     (hwdata),
    .hrdata     (hrdata),
    .hresp      (hresp),
    .rec_valid  (rec_valid),
    .rec_addr   (rec_addr),
    .rec_ctl    (rec_ctl),
    .rec_data   (rec_data),
    .rec_resp   (rec_resp),
    .rec_count  (rec_count)
  );

  always_comb begin
    rec_write = rec_ctl.write;
    rec_size  = rec_ctl.size;
    rec_burst = rec_ctl.burst;
  end

  AST_NO_PHANTOM: assert property (@(posedge hclk) disable iff (!hresetn)
    (hready && (htrans == TR_IDLE || htrans == TR_BUSY)) |=> !pend_valid);  // R2

  AST_NO_RECORD_WITHOUT_READY: assert property (@(posedge hclk) disable iff (!hresetn)
    !hready |=> !rec_valid);  // R4

endmodule

// File: tb/test_ahb_xfer_tap.sv
module test_ahb_xfer_tap;
  import ahb_tap_pkg::*;

  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [31:0] a;
    logic        w;
    logic [2:0]  sz;
    logic [2:0]  bu;
    logic [31:0] d;
    logic        r;
  } exp_t;

  logic        hclk = 1'b0;
  logic        hresetn = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = TR_IDLE;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = '0;
  logic [2:0]  hburst = '0;
  logic [31:0] hwdata = '0;
  logic [31:0] hrdata = '0;
  logic        hready = 1'b1;
  logic        hresp = 1'b0;
  logic        rec_valid;
  logic [31:0] rec_addr;
  logic        rec_write;
  logic [2:0]  rec_size;
  logic [2:0]  rec_burst;
  logic [31:0] rec_data;
  logic        rec_resp;
  logic [15:0] rec_count;

  int checks = 0;
  int failures = 0;
  int seen = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) hclk = ~hclk;

  ahb_xfer_tap i_ahb_xfer_tap (
    .hclk(hclk), .hresetn(hresetn), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
    .hrdata(hrdata), .hready(hready), .hresp(hresp),
    .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_write(rec_write),
    .rec_size(rec_size), .rec_burst(rec_burst), .rec_data(rec_data),
    .rec_resp(rec_resp), .rec_count(rec_count)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic expect_rec(input logic [31:0] a, input logic w, input logic [2:0] sz,
                            input logic [2:0] bu, input logic [31:0] d, input logic r,
                            input string tag);
    exp_t e;
    e.a = a; e.w = w; e.sz = sz; e.bu = bu; e.d = d; e.r = r;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // one bus cycle: driven at the falling edge, sampled by the next rising edge
  task automatic cyc(input logic [1:0] tr, input logic [31:0] a, input logic w,
                     input logic [2:0] sz, input logic [2:0] bu, input logic [31:0] wd,
                     input logic [31:0] rd, input logic rdy, input logic rsp);
    @(negedge hclk);
    htrans = tr; haddr = a; hwrite = w; hsize = sz; hburst = bu;
    hwdata = wd; hrdata = rd; hready = rdy; hresp = rsp;
  endtask

  task automatic idle(input logic [31:0] wd, input logic [31:0] rd);
    cyc(TR_IDLE, 32'hDEAD_0000, 1'b0, 3'd0, 3'd0, wd, rd, 1'b1, 1'b0);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 4; i++) idle(32'hBAD0_0000 + i, 32'hBAD1_0000 + i);
    @(negedge hclk);
    check(exp_q.size() == 0, tag, "records still missing", exp_q.size(), 0);
  endtask

  // record collector: one sample per cycle, away from the rising edge
  always @(negedge hclk) begin
    if (hresetn && rec_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected record addr", rec_addr, 0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rec_addr == e.a, t, "addr (R3)", rec_addr, e.a);
        check(rec_write == e.w, t, "write (R3)", rec_write, e.w);
        check(rec_size == e.sz, t, "size (R3)", rec_size, e.sz);
        check(rec_burst == e.bu, t, "burst (R3)", rec_burst, e.bu);
        check(rec_data == e.d, t, "data (R5)", rec_data, e.d);
        check(rec_resp == e.r, t, "resp (R5)", rec_resp, e.r);
      end
      seen++;
      check(rec_count == 16'(seen), "R10", "record count", rec_count, seen);
    end
  end

  task automatic t_reset;
    @(negedge hclk);
    check(rec_valid == 1'b0, "R9", "valid in reset", rec_valid, 0);
    check(rec_count == 16'd0, "R9", "count in reset", rec_count, 0);
  endtask

  task automatic t_single_write;
    expect_rec(32'h0000_1000, 1'b1, 3'd2, 3'd0, 32'hA5A5_0001, 1'b0, "R1");
    cyc(TR_NONSEQ, 32'h0000_1000, 1'b1, 3'd2, 3'd0, 32'h0, 32'h0, 1'b1, 1'b0);
    idle(32'hA5A5_0001, 32'h7777_7777);
    @(negedge hclk);
    check(rec_valid == 1'b1, "R6", "valid after completion", rec_valid, 1);
    @(negedge hclk);
    check(rec_valid == 1'b0, "R6", "valid one cycle only", rec_valid, 0);
    drain("R1");
  endtask

  task automatic t_read_waits;
    expect_rec(32'h0000_2040, 1'b0, 3'd1, 3'd0, 32'h1234_5678, 1'b0, "R4");
    cyc(TR_NONSEQ, 32'h0000_2040, 1'b0, 3'd1, 3'd0, 32'h0, 32'h0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++)
      cyc(TR_IDLE, 32'hFFFF_0000 + i, 1'b1, 3'd7, 3'd7, 32'hEEEE_0000 + i,
          32'hCCCC_0000 + i, 1'b0, 1'b0);
    idle(32'h9999_9999, 32'h1234_5678);
    drain("R4");
  endtask

  task automatic t_burst_busy;
    expect_rec(32'h0000_3000, 1'b1, 3'd2, 3'd3, 32'hD000_0000, 1'b0, "R2");
    expect_rec(32'h0000_3004, 1'b1, 3'd2, 3'd3, 32'hD000_0001, 1'b0, "R7");
    expect_rec(32'h0000_3008, 1'b1, 3'd2, 3'd3, 32'hD000_0002, 1'b0, "R7");
    expect_rec(32'h0000_300C, 1'b1, 3'd2, 3'd3, 32'hD000_0003, 1'b0, "R7");
    cyc(TR_NONSEQ, 32'h0000_3000, 1'b1, 3'd2, 3'd3, 32'h0, 32'h0, 1'b1, 1'b0);
    cyc(TR_BUSY,   32'h0000_3004, 1'b1, 3'd2, 3'd3, 32'hD000_0000, 32'h0, 1'b1, 1'b0);
    cyc(TR_SEQ,    32'h0000_3004, 1'b1, 3'd2, 3'd3, 32'h5555_5555, 32'h0, 1'b1, 1'b0);
    cyc(TR_SEQ,    32'h0000_3008, 1'b1, 3'd2, 3'd3, 32'hD000_0001, 32'h0, 1'b1, 1'b0);
    cyc(TR_SEQ,    32'h0000_300C, 1'b1, 3'd2, 3'd3, 32'h6666_6666, 32'h0, 1'b0, 1'b0);
    cyc(TR_SEQ,    32'h0000_300C, 1'b1, 3'd2, 3'd3, 32'hD000_0002, 32'h0, 1'b1, 1'b0);
    idle(32'hD000_0003, 32'h0);
    drain("R7");
  endtask

  task automatic t_mixed_pipeline;
    expect_rec(32'h0000_4000, 1'b1, 3'd2, 3'd0, 32'h0000_00A1, 1'b0, "R5");
    expect_rec(32'h0000_4100, 1'b0, 3'd0, 3'd1, 32'h0000_00B2, 1'b0, "R5");
    expect_rec(32'h0000_4200, 1'b1, 3'd1, 3'd0, 32'h0000_00C3, 1'b0, "R7");
    cyc(TR_NONSEQ, 32'h0000_4000, 1'b1, 3'd2, 3'd0, 32'h0, 32'h0, 1'b1, 1'b0);
    cyc(TR_NONSEQ, 32'h0000_4100, 1'b0, 3'd0, 3'd1, 32'h0000_00A1, 32'hFFFF_00A1, 1'b1, 1'b0);
    cyc(TR_NONSEQ, 32'h0000_4200, 1'b1, 3'd1, 3'd0, 32'hFFFF_00B2, 32'h0000_00B2, 1'b1, 1'b0);
    idle(32'h0000_00C3, 32'hFFFF_00C3);
    drain("R5");
  endtask

  task automatic t_error;
    expect_rec(32'h0000_5000, 1'b1, 3'd2, 3'd0, 32'h0E0E_0E0E, 1'b1, "R8");
    cyc(TR_NONSEQ, 32'h0000_5000, 1'b1, 3'd2, 3'd0, 32'h0, 32'h0, 1'b1, 1'b0);
    cyc(TR_NONSEQ, 32'h0000_5100, 1'b0, 3'd2, 3'd0, 32'h0E0E_0E0E, 32'h0, 1'b0, 1'b1);
    cyc(TR_IDLE,   32'h0000_5100, 1'b0, 3'd2, 3'd0, 32'h0E0E_0E0E, 32'h0, 1'b1, 1'b1);
    drain("R8");
  endtask

  task automatic t_reset_mid;
    cyc(TR_NONSEQ, 32'h0000_6000, 1'b0, 3'd2, 3'd0, 32'h0, 32'h0, 1'b1, 1'b0);
    cyc(TR_IDLE, 32'h0, 1'b0, 3'd0, 3'd0, 32'h0, 32'h6666_0000, 1'b0, 1'b0);
    @(negedge hclk);
    hresetn = 1'b0;
    seen = 0;
    @(negedge hclk);
    check(rec_count == 16'd0, "R9", "count after reset", rec_count, 0);
    check(rec_valid == 1'b0, "R9", "valid after reset", rec_valid, 0);
    hresetn = 1'b1;
    idle(32'h0, 32'h6666_0001);
    drain("R9");
    check(rec_count == 16'd0, "R9", "no record from pre-reset context", rec_count, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    t_reset();
    @(negedge hclk);
    hresetn = 1'b1;
    t_single_write();
    t_read_waits();
    t_burst_busy();
    t_mixed_pipeline();
    t_error();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule